// File: doc/BRIEF.md
# Double-Buffered Multi-Channel DAC Register Bank

This block is the digital front end of an array of 16 voltage DACs with 8-bit codes. The host sees the bank as memory on a parallel bus. Every channel has two ranks of storage. The first is a staging register that the host writes. The second is a converter register that drives the analog code for that channel.

Host writes land only in the staging rank. Pulling the active-low transfer input low moves every staging value into its converter register on the same clock edge. All 16 codes therefore change together. If the transfer input stays low, the bank is transparent, and each write reaches its converter register at once.

The host can read any staging register back over the bus to check what it wrote. The read data is driven only while the read strobe is high. An active-low asynchronous reset clears both ranks.

Top module: `dacbank_top`

## Requirements
- R1: While rst_ni is low, every channel of dac_o reads 0, and no clock edge is needed for this.
- R2: Reset also clears every staging register. A read after reset returns 0. A transfer after reset leaves dac_o at 0.
- R3: A clock edge with wr_i high stores wdata_i into the staging register of channel addr_i. All other staging registers keep their values.
- R4: A clock edge with load_ni high does not change any converter register, even when a write happens on that edge.
- R5: A clock edge with load_ni low copies all 16 staging values into the converter registers. Channel n appears at dac_o[8n+7:8n], and all channels update on that same edge.
- R6: A clock edge with both load_ni low and wr_i high puts the newly written wdata_i into the addressed channel's converter register on that edge. This holds both when load_ni is held low across several writes and when load_ni is a single-cycle pulse.
- R7: While rd_i is high, rd_data_o shows the staging register of channel addr_i and rd_oe_o is 1. While rd_i is low, rd_oe_o is 0 and rd_data_o is 0.
- R8: Channels 0 and 15, at the ends of the address range, behave like every other channel for write, read and transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Channel address for writes and reads |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, active high |
| rd_i | input | 1 | Read strobe, active high |
| load_ni | input | 1 | Transfer staging rank to converter rank, active low |
| rd_data_o | output | 8 | Readback data, zero when not reading |
| rd_oe_o | output | 1 | Bus drive enable for readback |
| dac_o | output | 128 | Converter codes, channel n at bits 8n+7:8n |

## Verification
The bench writes distinct values to every channel with the transfer input held high. Because the outputs must stay frozen while readback shows the new data, this separates the staging rank from the converter rank.

A single transfer pulse is then checked to move all 16 values on one edge. Holding the transfer low during a run of writes checks the transparent path. A write coinciding with a one-cycle transfer checks that the new value wins over the old staging value.

Reset is asserted between clock edges to confirm that it clears the outputs asynchronously. A transfer after reset confirms that the staging rank was cleared as well.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int unsigned DEF_NCH = 16;
  localparam int unsigned DEF_DW  = 8;
endpackage

// File: rtl/dacbank_addr_dec.sv
module dacbank_addr_dec #(
  parameter int unsigned NCH = 16,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_i,
  output logic [NCH-1:0] hit_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign hit_o[g] = wr_i && (addr_i == AW'(g));
  end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_hit_i,
  input  logic          load_ni,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] in_o,
  output logic [DW-1:0] dac_o
);
  logic [DW-1:0] in_q, dac_q, in_d;

  assign in_d = wr_hit_i ? wdata_i : in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= '0;
    else         in_q <= in_d;
  end

  // transfer takes the value being written this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dac_q <= '0;
    else if (!load_ni) dac_q <= in_d;
  end

  assign in_o  = in_q;
  assign dac_o = dac_q;

  p_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i |=> in_q == $past(wdata_i));
  p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> $stable(in_q));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni |=> $stable(dac_q));
  p_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && !wr_hit_i) |=> dac_q == $past(in_q));
  p_through_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && wr_hit_i) |=> dac_q == $past(wdata_i));
endmodule

// File: rtl/dacbank_rd_mux.sv
module dacbank_rd_mux #(
  parameter int unsigned NCH = 16,
  parameter int unsigned DW  = 8,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic [NCH*DW-1:0] in_flat_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (rd_i) rd_data_o = in_flat_i[addr_i*DW +: DW];
  end
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
  import dacbank_pkg::*;
#(
  parameter int unsigned NCH = DEF_NCH,
  parameter int unsigned DW  = DEF_DW,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              load_ni,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_oe_o,
  output logic [NCH*DW-1:0] dac_o
);
  logic [NCH-1:0]    hit;
  logic [NCH*DW-1:0] in_flat;

  dacbank_addr_dec #(.NCH(NCH)) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .hit_o(hit)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dacbank_chan #(.DW(DW)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_hit_i(hit[g]),
      .load_ni (load_ni),
      .wdata_i (wdata_i),
      .in_o    (in_flat[g*DW +: DW]),
      .dac_o   (dac_o[g*DW +: DW])
    );
  end

  dacbank_rd_mux #(.NCH(NCH), .DW(DW)) u_rd (
    .in_flat_i(in_flat), .addr_i(addr_i), .rd_i(rd_i), .rd_data_o(rd_data_o)
  );

  assign rd_oe_o = rd_i;

  p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  p_rd_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> rd_data_o == '0);
endmodule

// File: tb/dacbank_top_tb_top.sv
module dacbank_top_tb_top;
  localparam int NCH = 16;
  localparam int DW  = 8;

  logic clk = 0, rst_ni = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 0, rd = 0, load_n = 1;
  logic [7:0] rd_data;
  logic rd_oe;
  logic [NCH*DW-1:0] dac;

  int total = 0, bad = 0;
  logic [7:0] exp_in [NCH];
  logic [7:0] exp_dac [NCH];

  always #2.5 clk = ~clk;

  dacbank_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .load_ni(load_n),
    .rd_data_o(rd_data), .rd_oe_o(rd_oe), .dac_o(dac)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_dac(string req);
    for (int i = 0; i < NCH; i++) chk(req, dac[i*DW +: DW], exp_dac[i]);
  endtask

  task automatic chk_rd(string req);
    for (int i = 0; i < NCH; i++) begin
      @(negedge clk); rd = 1; addr = 4'(i);
      #1 chk(req, rd_data, exp_in[i]);
      chk(req, rd_oe, 1);
    end
    @(negedge clk); rd = 0;
    #1 chk("R7 idle", rd_data, 0);
    chk("R7 oe", rd_oe, 0);
  endtask

  // one bus cycle: inputs set at negedge, edge happens, model updated
  task automatic cyc(logic w, logic [3:0] a, logic [7:0] d, logic ln);
    @(negedge clk); wr = w; addr = a; wdata = d; load_n = ln;
    @(negedge clk);
    if (w) exp_in[a] = d;
    if (!ln) for (int i = 0; i < NCH; i++) exp_dac[i] = exp_in[i];
    wr = 0; load_n = 1;
  endtask

  task automatic t_reset;
    for (int i = 0; i < NCH; i++) begin exp_in[i] = 0; exp_dac[i] = 0; end
    #1 chk_dac("R1 reset");
    @(negedge clk); rst_ni = 1;
    chk_rd("R2 reset readback");
  endtask

  task automatic t_write_only;
    for (int i = 0; i < NCH; i++) cyc(1, 4'(i), 8'(8'h11 * i + 3), 1);
    chk_dac("R4 write no load");
    chk_rd("R3 readback");
    cyc(1, 4'd15, 8'hA5, 1);
    cyc(1, 4'd0, 8'h5A, 1);
    chk_rd("R8 edge channels");
    chk_dac("R4 edge write");
  endtask

  task automatic t_load;
    cyc(0, 4'd0, 8'h00, 0);
    chk_dac("R5 load all");
    chk(  "R8 ch15", dac[15*DW +: DW], 8'hA5);
    chk(  "R8 ch0", dac[7:0], 8'h5A);
    cyc(1, 4'd3, 8'h77, 1);
    chk_dac("R4 after load");
  endtask

  task automatic t_transparent;
    @(negedge clk); load_n = 0;
    for (int i = 0; i < 4; i++) begin
      wr = 1; addr = 4'(i * 5); wdata = 8'(8'hC0 + i);
      @(negedge clk);
      exp_in[i*5] = 8'(8'hC0 + i);
      for (int k = 0; k < NCH; k++) exp_dac[k] = exp_in[k];
      chk("R6 transparent", dac[(i*5)*DW +: DW], 8'(8'hC0 + i));
    end
    wr = 0; load_n = 1;
    chk_dac("R6 held low");
  endtask

  task automatic t_write_and_load;
    cyc(1, 4'd7, 8'h3C, 1);
    cyc(1, 4'd7, 8'hE1, 0);
    chk("R6 write+load", dac[7*DW +: DW], 8'hE1);
    chk_dac("R6 pulse all");
  endtask

  task automatic t_async_reset;
    @(negedge clk); #1 rst_ni = 0;
    #0.5;
    for (int i = 0; i < NCH; i++) begin exp_in[i] = 0; exp_dac[i] = 0; end
    chk_dac("R1 async");
    @(negedge clk); rst_ni = 1;
    cyc(0, 4'd0, 8'h00, 0);
    chk_dac("R2 load after reset");
    chk_rd("R2 readback after reset");
  endtask

  initial begin
    #40000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_write_only();
    t_load();
    t_transparent();
    t_write_and_load();
    t_async_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule